// File: doc/BRIEF.md
# Boundary Scan Instruction Datapath

This block is the instruction and data-register half of a standard 1149.1 test port on a memory device. An outside TAP state machine supplies one-hot strobes for the states that matter here: Test-Logic-Reset, Capture-IR, Shift-IR, Update-IR, Capture-DR, Shift-DR and Update-DR. The block holds a 3-bit instruction register and decodes it. The decoded instruction selects one of three serial paths between TDI and TDO: a 48-cell boundary register, a 32-bit identification register or a 1-bit bypass stage. The block also decides whether the data-out pins carry core data, preloaded test data, or nothing at all.

The instruction register acts as the block's state. There are five instruction states: EXTEST (000), IDCODE (001), SAMPLE Z (010), SAMPLE/PRELOAD (100) and BYPASS (111). Codes 011, 101 and 110 are reserved. The state moves only at Update-IR, where it takes the shifted value, and at Test-Logic-Reset or power-up, where it returns to IDCODE. The boundary register has a shift stage and an update (preload) stage. Cell 47 of the update stage is the output-bus control cell. The bus is driven when that cell is 1 and is high-impedance when it is 0, and this applies only while EXTEST is the current instruction. SAMPLE Z holds the bus high-impedance until the next Update-IR.

Top module: `bscan_datapath`

## Requirements
- R1: Capture-IR loads 001 into the instruction shift stage, so bits [1:0] are 01 and bit 2 is 0. Shift-IR moves TDI into bit 2, and bit 0 is presented on TDO. Update-IR makes the shifted code the current instruction. No other strobe changes the current instruction.
- R2: At power-up and at Test-Logic-Reset the current instruction becomes IDCODE (001). IDCODE selects a 32-bit identification register. Capture-DR loads the register with the ID parameter, with bit 0 forced to 1, and the register shifts out bit 0 first.
- R3: EXTEST (000), SAMPLE Z (010) and SAMPLE/PRELOAD (100) select the boundary register. BYPASS (111) and the reserved codes 011, 101 and 110 all select the bypass stage.
- R4: While the boundary register is selected, Capture-DR copies the pin_snap input into the shift stage. Each Shift-DR cycle moves the stage one cell toward cell 0. TDI enters cell 47 and cell 0 is presented on TDO.
- R5: Update-DR copies the boundary shift stage into the preload outputs bsr_par, but only while the boundary register is selected. In every other case bsr_par is unchanged.
- R6: Under bypass, Capture-DR loads 0 into the single bypass bit, and Shift-DR passes TDI to TDO with one stage of delay.
- R7: Under EXTEST, pin_q equals bsr_par[DQ_W-1:0] and pin_oe equals bsr_par[47].
- R8: Under SAMPLE Z, pin_oe is 0 whatever core_oe is. This lasts until an Update-IR loads a different code.
- R9: Under every instruction other than EXTEST and SAMPLE Z, pin_q equals core_q and pin_oe equals core_oe.
- R10: Preload cell 47 is 1 after power-up and is set to 1 again by Test-Logic-Reset. The other preload cells reset to 0 and are not changed by Test-Logic-Reset.
- R11: tdo and tdo_en change on the falling edge of tck. tdo_en is 1 after a falling edge at which Shift-IR or Shift-DR is asserted, and 0 otherwise. While tdo_en is 0, tdo is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| st_tlr | input | 1 | TAP is in Test-Logic-Reset |
| st_capture_ir | input | 1 | TAP is in Capture-IR |
| st_shift_ir | input | 1 | TAP is in Shift-IR |
| st_update_ir | input | 1 | TAP is in Update-IR |
| st_capture_dr | input | 1 | TAP is in Capture-DR |
| st_shift_dr | input | 1 | TAP is in Shift-DR |
| st_update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial test data in |
| pin_snap | input | BSR_LEN | Pin values sampled by the boundary cells |
| core_q | input | DQ_W | Functional output data from the core |
| core_oe | input | 1 | Functional output enable from the core |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdo_en | output | 1 | TDO driver enable |
| bsr_par | output | BSR_LEN | Boundary preload (update stage) outputs |
| pin_q | output | DQ_W | Data toward the output pins |
| pin_oe | output | 1 | Output-bus enable toward the pins |

## Verification
The hardest situation to reach is a stale instruction state. An example is SAMPLE Z still holding the bus off while boundary data is shifted and updated underneath it. Another is a Test-Logic-Reset that arrives while the control cell holds 0. No single strobe creates either case. The stimulus builds each one from full instruction loads and boundary shifts. It first preloads cell 47 to 1 and then to 0 under EXTEST. It then enters SAMPLE Z, runs a complete Shift-DR/Update-DR under it, and leaves through BYPASS. The last boundary pattern leaves cell 47 at 0, so the following Test-Logic-Reset is seen to restore it. A behavioural model compares every output on every clock.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
    localparam int IR_W = 3;

    typedef enum logic [IR_W-1:0] {
        INS_EXTEST  = 3'b000,
        INS_IDCODE  = 3'b001,
        INS_SAMPLEZ = 3'b010,
        INS_RSV3    = 3'b011,
        INS_SAMPLE  = 3'b100,
        INS_RSV5    = 3'b101,
        INS_RSV6    = 3'b110,
        INS_BYPASS  = 3'b111
    } instr_e;

    typedef enum logic [1:0] {
        PATH_BSR,
        PATH_ID,
        PATH_BYP
    } path_e;

    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;
endpackage

// File: rtl/bscan_ir.sv
module bscan_ir
    import bscan_pkg::*;
(
    input  logic   tck,
    input  logic   rst_n,
    input  logic   st_tlr,
    input  logic   st_capture_ir,
    input  logic   st_shift_ir,
    input  logic   st_update_ir,
    input  logic   tdi,
    output instr_e ir_cur,
    output path_e  path_sel,
    output logic   ir_tdo
);
    logic [IR_W-1:0] sh_q;
    instr_e          ir_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)             sh_q <= '0;
        else if (st_capture_ir) sh_q <= IR_CAPTURE;
        else if (st_shift_ir)   sh_q <= {tdi, sh_q[IR_W-1:1]};
    end

    // instruction state register: moves only at Update-IR or reset
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)            ir_q <= INS_IDCODE;
        else if (st_tlr)       ir_q <= INS_IDCODE;
        else if (st_update_ir) ir_q <= instr_e'(sh_q);
    end

    always_comb begin
        unique case (ir_q)
            INS_EXTEST, INS_SAMPLEZ, INS_SAMPLE: path_sel = PATH_BSR;
            INS_IDCODE:                          path_sel = PATH_ID;
            default:                             path_sel = PATH_BYP;
        endcase
    end

    assign ir_cur = ir_q;
    assign ir_tdo = sh_q[0];

    // R2
    tlr_idcode_chk: assert property (@(posedge tck) disable iff (!rst_n)
        st_tlr |=> ir_q == INS_IDCODE);
    // R1
    ir_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (!st_update_ir && !st_tlr) |=> $stable(ir_q));
endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr #(
    parameter int N        = 48,
    parameter int CTRL_IDX = 47
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         st_tlr,
    input  logic         st_capture_dr,
    input  logic         st_shift_dr,
    input  logic         st_update_dr,
    input  logic         sel,
    input  logic         tdi,
    input  logic [N-1:0] pin_snap,
    output logic [N-1:0] upd_q,
    output logic         ser_out
);
    localparam logic [N-1:0] UPD_RST = {{(N-1){1'b0}}, 1'b1} << CTRL_IDX;

    logic [N-1:0] sh_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else if (sel) begin
            if (st_capture_dr)    sh_q <= pin_snap;
            else if (st_shift_dr) sh_q <= {tdi, sh_q[N-1:1]};
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                    upd_q <= UPD_RST;
        else if (st_tlr)               upd_q[CTRL_IDX] <= 1'b1;
        else if (sel && st_update_dr)  upd_q <= sh_q;
    end

    assign ser_out = sh_q[0];

    // R10
    tlr_ctrl_chk: assert property (@(posedge tck) disable iff (!rst_n)
        st_tlr |=> upd_q[CTRL_IDX]);
    // R5
    upd_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (!(sel && st_update_dr) && !st_tlr) |=> $stable(upd_q));
    // R5
    upd_load_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (sel && st_update_dr && !st_tlr) |=> upd_q == $past(sh_q));
endmodule

// File: rtl/bscan_aux.sv
module bscan_aux #(
    parameter logic [31:0] ID_VAL = 32'h0C0F_F069
) (
    input  logic tck,
    input  logic rst_n,
    input  logic st_capture_dr,
    input  logic st_shift_dr,
    input  logic sel_id,
    input  logic sel_byp,
    input  logic tdi,
    output logic id_out,
    output logic byp_out
);
    localparam int          ID_W   = 32;
    localparam logic [ID_W-1:0] ID_CAP = ID_VAL | 32'd1;

    logic [ID_W-1:0] id_q;
    logic            byp_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) id_q <= '0;
        else if (sel_id) begin
            if (st_capture_dr)    id_q <= ID_CAP;
            else if (st_shift_dr) id_q <= {tdi, id_q[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) byp_q <= 1'b0;
        else if (sel_byp) begin
            if (st_capture_dr)    byp_q <= 1'b0;
            else if (st_shift_dr) byp_q <= tdi;
        end
    end

    assign id_out  = id_q[0];
    assign byp_out = byp_q;

    // R6
    byp_pass_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (sel_byp && st_shift_dr && !st_capture_dr) |=> byp_q == $past(tdi));
    // R2
    id_lsb_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (sel_id && st_capture_dr) |=> id_q[0]);
endmodule

// File: rtl/bscan_datapath.sv
module bscan_datapath
    import bscan_pkg::*;
#(
    parameter int          BSR_LEN  = 48,
    parameter int          CTRL_IDX = 47,
    parameter int          DQ_W     = 18,
    parameter logic [31:0] ID_VAL   = 32'h0C0F_F069
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               st_tlr,
    input  logic               st_capture_ir,
    input  logic               st_shift_ir,
    input  logic               st_update_ir,
    input  logic               st_capture_dr,
    input  logic               st_shift_dr,
    input  logic               st_update_dr,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_snap,
    input  logic [DQ_W-1:0]    core_q,
    input  logic               core_oe,
    output logic               tdo,
    output logic               tdo_en,
    output logic [BSR_LEN-1:0] bsr_par,
    output logic [DQ_W-1:0]    pin_q,
    output logic               pin_oe
);
    instr_e ir_cur;
    path_e  path_sel;
    logic   ir_tdo, bsr_out, id_out, byp_out, ser;
    logic   shifting;

    bscan_ir u_ir (
        .tck(tck), .rst_n(rst_n), .st_tlr(st_tlr),
        .st_capture_ir(st_capture_ir), .st_shift_ir(st_shift_ir),
        .st_update_ir(st_update_ir), .tdi(tdi),
        .ir_cur(ir_cur), .path_sel(path_sel), .ir_tdo(ir_tdo)
    );

    bscan_bsr #(.N(BSR_LEN), .CTRL_IDX(CTRL_IDX)) u_bsr (
        .tck(tck), .rst_n(rst_n), .st_tlr(st_tlr),
        .st_capture_dr(st_capture_dr), .st_shift_dr(st_shift_dr),
        .st_update_dr(st_update_dr), .sel(path_sel == PATH_BSR),
        .tdi(tdi), .pin_snap(pin_snap), .upd_q(bsr_par), .ser_out(bsr_out)
    );

    bscan_aux #(.ID_VAL(ID_VAL)) u_aux (
        .tck(tck), .rst_n(rst_n),
        .st_capture_dr(st_capture_dr), .st_shift_dr(st_shift_dr),
        .sel_id(path_sel == PATH_ID), .sel_byp(path_sel == PATH_BYP),
        .tdi(tdi), .id_out(id_out), .byp_out(byp_out)
    );

    assign shifting = st_shift_ir | st_shift_dr;

    always_comb begin
        if (st_shift_ir) ser = ir_tdo;
        else begin
            unique case (path_sel)
                PATH_BSR: ser = bsr_out;
                PATH_ID:  ser = id_out;
                default:  ser = byp_out;
            endcase
        end
    end

    // serial output stage on the falling edge
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            tdo_en <= 1'b0;
            tdo    <= 1'b0;
        end else begin
            tdo_en <= shifting;
            tdo    <= shifting ? ser : 1'b0;
        end
    end

    // pin outputs selected by the instruction state
    always_comb begin
        pin_q  = core_q;
        pin_oe = core_oe;
        unique case (ir_cur)
            INS_EXTEST: begin
                pin_q  = bsr_par[DQ_W-1:0];
                pin_oe = bsr_par[CTRL_IDX];
            end
            INS_SAMPLEZ: pin_oe = 1'b0;
            default: ;
        endcase
    end

    // R8
    samplez_hiz_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_cur == INS_SAMPLEZ) |-> !pin_oe);
    // R11
    tdo_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !tdo_en |-> !tdo);
endmodule

// File: tb/bscan_datapath_tb.sv
module bscan_datapath_tb_top;
    localparam int T = 12;
    localparam int NB = 48;
    localparam int DW = 18;
    localparam logic [31:0] IDV = 32'h0C0F_F069;

    logic tck = 1'b0, rst_n = 1'b0;
    logic st_tlr = 0, st_capture_ir = 0, st_shift_ir = 0, st_update_ir = 0;
    logic st_capture_dr = 0, st_shift_dr = 0, st_update_dr = 0, tdi = 0;
    logic [NB-1:0] pin_snap = '0;
    logic [DW-1:0] core_q = '0;
    logic          core_oe = 1'b0;
    logic tdo, tdo_en, pin_oe;
    logic [NB-1:0] bsr_par;
    logic [DW-1:0] pin_q;

    int n_run = 0, n_fail = 0;

    bscan_datapath dut_i (
        .tck(tck), .rst_n(rst_n), .st_tlr(st_tlr),
        .st_capture_ir(st_capture_ir), .st_shift_ir(st_shift_ir), .st_update_ir(st_update_ir),
        .st_capture_dr(st_capture_dr), .st_shift_dr(st_shift_dr), .st_update_dr(st_update_dr),
        .tdi(tdi), .pin_snap(pin_snap), .core_q(core_q), .core_oe(core_oe),
        .tdo(tdo), .tdo_en(tdo_en), .bsr_par(bsr_par), .pin_q(pin_q), .pin_oe(pin_oe)
    );

    always #(T/2) tck = ~tck;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [2:0]  m_ir, m_irsh;
    bit        m_bsh[$];
    bit        m_id[$];
    bit [NB-1:0] m_upd;
    bit        m_byp, m_tdo, m_tdoen;
    string     m_src;

    function automatic int m_sel(bit [2:0] c);
        if (c == 3'b000 || c == 3'b010 || c == 3'b100) return 0;
        if (c == 3'b001) return 1;
        return 2;
    endfunction

    task automatic m_reset();
        m_ir = 3'b001; m_irsh = 0; m_upd = '0; m_upd[47] = 1'b1;
        m_byp = 0; m_tdo = 0; m_tdoen = 0;
        m_bsh.delete(); m_id.delete();
        for (int i = 0; i < NB; i++) m_bsh.push_back(1'b0);
        for (int i = 0; i < 32; i++) m_id.push_back(1'b0);
    endtask

    initial m_reset();

    always @(posedge tck) begin
        if (!rst_n) m_reset();
        else begin
            int s;
            s = m_sel(m_ir);
            if (st_tlr) m_upd[47] = 1'b1;
            else if (s == 0 && st_update_dr)
                for (int i = 0; i < NB; i++) m_upd[i] = m_bsh[i];
            if (s == 0 && st_capture_dr) begin
                m_bsh.delete();
                for (int i = 0; i < NB; i++) m_bsh.push_back(pin_snap[i]);
            end else if (s == 0 && st_shift_dr) begin
                void'(m_bsh.pop_front()); m_bsh.push_back(tdi);
            end
            if (s == 1 && st_capture_dr) begin
                m_id.delete();
                for (int i = 0; i < 32; i++) m_id.push_back(i == 0 ? 1'b1 : IDV[i]);
            end else if (s == 1 && st_shift_dr) begin
                void'(m_id.pop_front()); m_id.push_back(tdi);
            end
            if (s == 2 && st_capture_dr) m_byp = 0;
            else if (s == 2 && st_shift_dr) m_byp = tdi;
            if (st_tlr) m_ir = 3'b001;
            else if (st_update_ir) m_ir = m_irsh;
            if (st_capture_ir) m_irsh = 3'b001;
            else if (st_shift_ir) m_irsh = {tdi, m_irsh[2:1]};
        end
    end

    always @(negedge tck) begin
        if (!rst_n) begin m_tdo = 0; m_tdoen = 0; m_src = "R11"; end
        else begin
            m_tdoen = st_shift_ir | st_shift_dr;
            if (!m_tdoen) begin m_tdo = 0; m_src = "R11"; end
            else if (st_shift_ir) begin m_tdo = m_irsh[0]; m_src = "R1"; end
            else case (m_sel(m_ir))
                0: begin m_tdo = m_bsh[0]; m_src = "R4"; end
                1: begin m_tdo = m_id[0];  m_src = "R2"; end
                default: begin m_tdo = m_byp; m_src = (m_ir == 3'b111) ? "R6" : "R3"; end
            endcase
        end
    end

    // compare every clock, a quarter period after the falling edge
    always @(negedge tck) begin
        #(T/4);
        if (rst_n) begin
            chk(m_src, "tdo", 64'(tdo), 64'(m_tdo));
            chk("R11", "tdo_en", 64'(tdo_en), 64'(m_tdoen));
            chk("R5", "bsr_par", 64'(bsr_par), 64'(m_upd));
            if (m_ir == 3'b000) begin
                chk("R7", "pin_q", 64'(pin_q), 64'(m_upd[DW-1:0]));
                chk("R7", "pin_oe", 64'(pin_oe), 64'(m_upd[47]));
            end else if (m_ir == 3'b010) begin
                chk("R8", "pin_oe", 64'(pin_oe), 64'd0);
                chk("R9", "pin_q", 64'(pin_q), 64'(core_q));
            end else begin
                chk("R9", "pin_q", 64'(pin_q), 64'(core_q));
                chk("R9", "pin_oe", 64'(pin_oe), 64'(core_oe));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input bit tl = 0, input bit cir = 0, input bit sir = 0, input bit uir = 0,
                       input bit cdr = 0, input bit sdr = 0, input bit udr = 0, input bit d = 0);
        @(posedge tck); #(T/4);
        st_tlr = tl; st_capture_ir = cir; st_shift_ir = sir; st_update_ir = uir;
        st_capture_dr = cdr; st_shift_dr = sdr; st_update_dr = udr; tdi = d;
    endtask

    task automatic load_ir(input logic [2:0] code);
        cyc(.cir(1));
        for (int i = 0; i < 3; i++) begin
            cyc(.sir(1), .d(code[i]));
            #(T/2);
            chk("R1", "ir capture bit", 64'(tdo), 64'(i == 0));
        end
        cyc(.uir(1));
        cyc();
    endtask

    task automatic shift_dr(input int n, input logic [63:0] v);
        cyc(.cdr(1));
        for (int i = 0; i < n; i++) cyc(.sdr(1), .d(v[i]));
        cyc(.udr(1));
        cyc();
    endtask

    initial begin
        logic [63:0] pat;
        #(T*100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] pat;
        repeat (2) @(posedge tck);
        #(T/4) rst_n = 1'b1;
        core_q = 18'h2A5C3; core_oe = 1'b1;
        cyc(); #(T/2);
        chk("R10", "reset ctrl cell", 64'(bsr_par), 64'(48'h1 << 47));
        chk("R9", "reset pin_oe", 64'(pin_oe), 64'd1);

        // R2: IDCODE path after reset
        shift_dr(32, 64'h0);
        // R4/R5: SAMPLE/PRELOAD capture + preload, control cell 1
        pin_snap = 48'hC3A5_1E0F_9B27;
        load_ir(3'b100);
        pat = 64'h8000_5555_AAAA | 64'h1_2345;
        shift_dr(NB, pat);
        chk("R5", "preload after update", 64'(bsr_par), 64'(pat[NB-1:0]));
        // R7: EXTEST drives preload, bus enabled
        load_ir(3'b000);
        #(T/2);
        chk("R7", "extest pin_q", 64'(pin_q), 64'(pat[DW-1:0]));
        chk("R7", "extest pin_oe on", 64'(pin_oe), 64'd1);
        shift_dr(NB, 64'h0000_0F0F_3C3C);
        #(T/2);
        chk("R7", "extest pin_oe off", 64'(pin_oe), 64'd0);
        // R8: SAMPLE Z holds the bus off across a DR scan
        core_oe = 1'b1;
        load_ir(3'b010);
        #(T/2);
        chk("R8", "samplez hiz", 64'(pin_oe), 64'd0);
        pin_snap = 48'h1234_5678_9ABC;
        shift_dr(NB, 64'h7FFF_0000_FFFF);
        #(T/2);
        chk("R8", "samplez after dr", 64'(pin_oe), 64'd0);
        // R6: BYPASS releases the bus and leaves preload alone
        load_ir(3'b111);
        #(T/2);
        chk("R8", "left samplez", 64'(pin_oe), 64'd1);
        pat = {16'h0, bsr_par};
        shift_dr(8, 64'hB6);
        chk("R5", "bypass update ignored", 64'(bsr_par), pat);
        // R3: reserved code behaves as bypass
        load_ir(3'b101);
        shift_dr(6, 64'h2D);
        load_ir(3'b011);
        shift_dr(5, 64'h13);
        chk("R3", "reserved update ignored", 64'(bsr_par), pat);
        // R10/R2: Test-Logic-Reset restores control cell and IDCODE
        load_ir(3'b000);
        cyc(.tl(1));
        cyc(); #(T/2);
        chk("R10", "tlr ctrl cell", 64'(bsr_par[47]), 64'd1);
        chk("R10", "tlr other cells", 64'(bsr_par[46:0]), 64'(pat[46:0]));
        shift_dr(32, 64'hFFFF_FFFF);
        repeat (3) cyc();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule